// File: doc/BRIEF.md
# Multi-Slot Retire Queue

This block is a circular queue for in-order retirement. Each instruction takes a contiguous run of slots, one slot per micro-op. When the dispatch side asks for a reservation, the queue returns a token. The token is the slot index where the run starts, and it names the instruction from then on.

The execution side reports completion by presenting that token. The queue then retires instructions from the oldest end. An instruction retires only once it has completed, and the queue never retires more entries per cycle than a configurable limit allows. Retiring an instruction frees every slot of its run.

The free-slot count is an output. Dispatch logic uses it to throttle itself. When a request does not fit, the block raises a stall for that cycle.

Top module: `rq_retire_queue`

## Requirements
- R1: After reset the free-slot count equals DEPTH, the offered token is 0, no retirement is reported and stall is low.
- R2: The slot quantity of a request is the micro-op count limited to DEPTH, and then raised to at least 1. A count of 0 takes one slot, and any count above DEPTH takes DEPTH slots.
- R3: While a request is offered, the token output shows the current tail index. On an accepted request the tail moves forward by the quantity modulo DEPTH, wrapping past slot DEPTH-1 to 0, and the free count drops by the quantity.
- R4: A request is accepted only when the free count before this cycle's retirement is at least its quantity. Otherwise stall is high, and neither the tail nor the free count changes.
- R5: A completion with a valid token sets that entry's completed flag. A completed entry that is younger than an uncompleted head does not retire.
- R6: When the head entry has completed, it retires. The head then moves forward by the entry's slot count modulo DEPTH, and the free count grows by that count. The token output of the oldest entry equals the head index.
- R7: At most RET_MAX entries retire in one cycle, always in order. RET_MAX = 0 removes the limit.
- R8: A completion whose token is not the start of a live entry, or whose entry has already completed, raises the error output in that cycle. Such a completion changes no state.
- R9: A request and a retirement in the same cycle are both performed. The request is judged against the free count from before the retirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsv_valid | input | 1 | Reservation request |
| rsv_uops | input | UOP_W | Micro-op count of the request |
| rsv_accept | output | 1 | Request accepted this cycle |
| rsv_stall | output | 1 | Request refused for lack of space |
| rsv_token | output | IDX_W | Current tail index, the token of an accepted request |
| done_valid | input | 1 | Completion report |
| done_token | input | IDX_W | Token of the completed instruction |
| done_err | output | 1 | Completion token invalid or already completed |
| free_slots | output | CNT_W | Number of free slots |
| ret_num | output | CNT_W | Entries retiring this cycle |
| ret_token | output | IDX_W | Head index, the token of the oldest entry |

## Verification
The assertions assume that completion tokens arrive only while the queue is out of reset. They assume no request is made during reset. They also assume the free count is the sole guard on reservations, so no outside ordering between reserve and completion is required.

The stimulus drives a single request and a single completion per cycle. It changes inputs only on the falling edge. It deliberately includes erroneous completion tokens, because the design must flag these rather than rely on them being absent. A second instance with no retire limit shares the stimulus, so both limit settings see identical entry histories.

// File: rtl/rq_pkg.sv
package rq_pkg;

  // Slot quantity: limited to the depth, at least one
  function automatic int rq_qty(input int uops, input int depth);
    int q;
    q = (uops > depth) ? depth : uops;
    if (q < 1) q = 1;
    return q;
  endfunction

  // Circular index advance
  function automatic int rq_wrap(input int idx, input int step, input int depth);
    return (idx + step) % depth;
  endfunction

endpackage

// File: rtl/rq_alloc.sv
module rq_alloc #(
  parameter int DEPTH = 16,
  parameter int UOP_W = 6,
  parameter int CNT_W = 5
) (
  input  logic             req,
  input  logic [UOP_W-1:0] uops,
  input  logic [CNT_W-1:0] free_cnt,
  output logic [CNT_W-1:0] qty,
  output logic             accept,
  output logic             stall
);
  import rq_pkg::*;

  logic fits;

  always_comb begin
    qty    = CNT_W'(rq_qty(int'(uops), DEPTH));
    fits   = (free_cnt >= qty);
    accept = req && fits;
    stall  = req && !fits;
  end

endmodule

// File: rtl/rq_slot_table.sv
module rq_slot_table #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4,
  parameter int CNT_W = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        alloc_en,
  input  logic [IDX_W-1:0]            alloc_idx,
  input  logic [CNT_W-1:0]            alloc_len,
  input  logic                        mark_en,
  input  logic [IDX_W-1:0]            mark_idx,
  input  logic [DEPTH-1:0]            clr_mask,
  output logic [DEPTH-1:0]            occ,
  output logic [DEPTH-1:0]            exe,
  output logic [DEPTH-1:0][CNT_W-1:0] len,
  output logic                        mark_err
);

  logic mark_ok;

  always_comb begin
    mark_err = mark_en && (!occ[mark_idx] || exe[mark_idx]);
    mark_ok  = mark_en && !mark_err;
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic hit_alloc, hit_mark;
    assign hit_alloc = alloc_en && (int'(alloc_idx) == s);
    assign hit_mark  = mark_ok && (int'(mark_idx) == s);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        occ[s] <= 1'b0;
        exe[s] <= 1'b0;
        len[s] <= '0;
      end else begin
        if (clr_mask[s]) begin
          occ[s] <= 1'b0;
          exe[s] <= 1'b0;
        end
        if (hit_mark) exe[s] <= 1'b1;
        if (hit_alloc) begin
          occ[s] <= 1'b1;
          exe[s] <= 1'b0;
          len[s] <= alloc_len;
        end
      end
    end
  end

  AST_MARK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_en && !mark_err) |=> exe[$past(mark_idx)]); // R5

  AST_ERR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_err && !alloc_en && (clr_mask == '0)) |=> (exe == $past(exe))); // R8

endmodule

// File: rtl/rq_retire_scan.sv
module rq_retire_scan #(
  parameter int DEPTH   = 16,
  parameter int RET_MAX = 2,
  parameter int IDX_W   = 4,
  parameter int CNT_W   = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            head,
  input  logic [CNT_W-1:0]            used,
  input  logic [DEPTH-1:0]            occ,
  input  logic [DEPTH-1:0]            exe,
  input  logic [DEPTH-1:0][CNT_W-1:0] len,
  output logic [CNT_W-1:0]            ret_num,
  output logic [CNT_W-1:0]            ret_slots,
  output logic [DEPTH-1:0]            clr_mask,
  output logic [IDX_W-1:0]            new_head
);
  import rq_pkg::*;

  localparam int LIM = (RET_MAX == 0 || RET_MAX > DEPTH) ? DEPTH : RET_MAX;

  always_comb begin
    int  ptr, acc, n;
    logic go;
    ptr      = int'(head);
    acc      = 0;
    n        = 0;
    go       = 1'b1;
    clr_mask = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (go && acc < int'(used) && n < LIM && occ[ptr] && exe[ptr]) begin
        clr_mask[ptr] = 1'b1;
        acc = acc + int'(len[ptr]);
        n   = n + 1;
        ptr = rq_wrap(ptr, int'(len[ptr]), DEPTH);
      end else begin
        go = 1'b0;
      end
    end
    ret_num   = CNT_W'(n);
    ret_slots = CNT_W'(acc);
    new_head  = IDX_W'(ptr);
  end

  AST_RETIRE_NEEDS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_num != '0) |-> (occ[head] && exe[head])); // R5

  AST_RETIRE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ret_num) <= LIM); // R7

  AST_EMPTY_NO_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (used == '0) |-> (ret_num == '0)); // R6

endmodule

// File: rtl/rq_retire_queue.sv
module rq_retire_queue #(
  parameter int DEPTH   = 16,
  parameter int UOP_W   = 6,
  parameter int RET_MAX = 2,
  parameter int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rsv_valid,
  input  logic [UOP_W-1:0] rsv_uops,
  output logic             rsv_accept,
  output logic             rsv_stall,
  output logic [IDX_W-1:0] rsv_token,
  input  logic             done_valid,
  input  logic [IDX_W-1:0] done_token,
  output logic             done_err,
  output logic [CNT_W-1:0] free_slots,
  output logic [CNT_W-1:0] ret_num,
  output logic [IDX_W-1:0] ret_token
);
  import rq_pkg::*;

  logic [IDX_W-1:0]            head_q, tail_q, head_n;
  logic [CNT_W-1:0]            free_q, qty, ret_slots, used;
  logic [DEPTH-1:0]            occ, exe, clr_mask;
  logic [DEPTH-1:0][CNT_W-1:0] len;

  assign used = CNT_W'(DEPTH) - free_q;

  rq_alloc #(.DEPTH(DEPTH), .UOP_W(UOP_W), .CNT_W(CNT_W)) u_alloc (
    .req(rsv_valid), .uops(rsv_uops), .free_cnt(free_q),
    .qty(qty), .accept(rsv_accept), .stall(rsv_stall)
  );

  rq_slot_table #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(rsv_accept), .alloc_idx(tail_q), .alloc_len(qty),
    .mark_en(done_valid), .mark_idx(done_token),
    .clr_mask(clr_mask),
    .occ(occ), .exe(exe), .len(len), .mark_err(done_err)
  );

  rq_retire_scan #(.DEPTH(DEPTH), .RET_MAX(RET_MAX), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_scan (
    .clk(clk), .rst_n(rst_n),
    .head(head_q), .used(used), .occ(occ), .exe(exe), .len(len),
    .ret_num(ret_num), .ret_slots(ret_slots), .clr_mask(clr_mask), .new_head(head_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      free_q <= CNT_W'(DEPTH);
    end else begin
      head_q <= head_n;
      if (rsv_accept)
        tail_q <= IDX_W'(rq_wrap(int'(tail_q), int'(qty), DEPTH));
      free_q <= free_q - (rsv_accept ? qty : '0) + ret_slots;
    end
  end

  assign rsv_token  = tail_q;
  assign free_slots = free_q;
  assign ret_token  = head_q;

  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_slots) <= DEPTH); // R3

  AST_TAIL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_accept |=> int'(rsv_token) == rq_wrap(int'($past(rsv_token)), int'($past(qty)), DEPTH)); // R3

  AST_STALL_HOLDS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_stall |=> $stable(rsv_token)); // R4

  AST_HEAD_MOVES_ON_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_num == '0) |=> $stable(ret_token)); // R6

endmodule

// File: tb/test_rq_retire_queue.sv
module test_rq_retire_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int UOP_W = 4;
  localparam int IDX_W = 3;
  localparam int CNT_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rsv_valid = 1'b0, done_valid = 1'b0;
  logic [UOP_W-1:0] rsv_uops = '0;
  logic [IDX_W-1:0] done_token = '0;
  logic rsv_accept, rsv_stall, done_err;
  logic [IDX_W-1:0] rsv_token, ret_token;
  logic [CNT_W-1:0] free_slots, ret_num;
  logic u_accept, u_stall, u_err;
  logic [IDX_W-1:0] u_token, u_rtok;
  logic [CNT_W-1:0] u_free, u_ret_num;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rq_retire_queue #(.DEPTH(DEPTH), .UOP_W(UOP_W), .RET_MAX(2)) i_rq_retire_queue (
    .clk(clk), .rst_n(rst_n), .rsv_valid(rsv_valid), .rsv_uops(rsv_uops),
    .rsv_accept(rsv_accept), .rsv_stall(rsv_stall), .rsv_token(rsv_token),
    .done_valid(done_valid), .done_token(done_token), .done_err(done_err),
    .free_slots(free_slots), .ret_num(ret_num), .ret_token(ret_token));

  rq_retire_queue #(.DEPTH(DEPTH), .UOP_W(UOP_W), .RET_MAX(0)) i_rq_unl (
    .clk(clk), .rst_n(rst_n), .rsv_valid(rsv_valid), .rsv_uops(rsv_uops),
    .rsv_accept(u_accept), .rsv_stall(u_stall), .rsv_token(u_token),
    .done_valid(done_valid), .done_token(done_token), .done_err(u_err),
    .free_slots(u_free), .ret_num(u_ret_num), .ret_token(u_rtok));

  // {uops, expected token, expected accept, expected free after}
  localparam int VEC [5][4] = '{
    '{0,  0, 1, 7},
    '{3,  1, 1, 4},
    '{15, 4, 0, 4},
    '{2,  4, 1, 2},
    '{4,  6, 0, 2}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive a request at the falling edge, check the offer, commit at the rising edge
  task automatic reserve(input int uops, input int exp_tok, input int exp_acc);
    @(negedge clk);
    rsv_valid = 1'b1;
    rsv_uops  = UOP_W'(uops);
    #1;
    chk("R3 token", int'(rsv_token), exp_tok);
    chk("R4 accept", int'(rsv_accept), exp_acc);
    chk("R4 stall", int'(rsv_stall), 1 - exp_acc);
    @(posedge clk);
    @(negedge clk);
    rsv_valid = 1'b0;
  endtask

  task automatic mark(input int tok, input int exp_err);
    @(negedge clk);
    done_valid = 1'b1;
    done_token = IDX_W'(tok);
    #1;
    chk("R8 done_err", int'(done_err), exp_err);
    @(posedge clk);
    @(negedge clk);
    done_valid = 1'b0;
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 free", int'(free_slots), DEPTH);
    chk("R1 token", int'(rsv_token), 0);
    chk("R1 ret_num", int'(ret_num), 0);
    chk("R1 stall", int'(rsv_stall), 0);

    // R2, R3, R4: clamping, tail advance and stall from the vector table
    foreach (VEC[i]) begin
      reserve(VEC[i][0], VEC[i][1], VEC[i][2]);
      #1;
      chk("R2 free after request", int'(free_slots), VEC[i][3]);
    end
    // Live entries now: tok0 len1, tok1 len3, tok4 len2

    // R8: a token in the middle of an entry
    mark(2, 1);
    chk("R8 no retire", int'(ret_num), 0);
    chk("R8 free unchanged", int'(free_slots), 2);

    // R5: a younger completion does not retire
    mark(4, 0);
    chk("R5 young held", int'(ret_num), 0);
    chk("R5 head token", int'(ret_token), 0);
    mark(0, 0);
    chk("R6 head retires", int'(ret_num), 1);
    @(negedge clk); #1;
    chk("R6 free grows", int'(free_slots), 3);
    chk("R6 head advances", int'(ret_token), 1);

    // R8: completing an entry twice
    mark(4, 1);
    mark(1, 0);
    chk("R6 two retire", int'(ret_num), 2);
    @(negedge clk); #1;
    chk("R6 free full", int'(free_slots), 8);
    chk("R6 head at tail", int'(ret_token), 6);

    // R3 wrap and R7 limit with three single-slot entries
    reserve(1, 6, 1);
    reserve(1, 7, 1);
    reserve(1, 0, 1);
    chk("R3 wrap tail", int'(rsv_token), 1);
    mark(0, 0);
    mark(7, 0);
    chk("R5 head not done", int'(ret_num), 0);
    mark(6, 0);
    chk("R7 limited", int'(ret_num), 2);
    chk("R7 unlimited", int'(u_ret_num), 3);
    @(negedge clk); #1;
    chk("R7 remainder", int'(ret_num), 1);
    chk("R7 unlimited done", int'(u_ret_num), 0);
    @(negedge clk); #1;
    chk("R7 free", int'(free_slots), 8);

    // R9: full queue, a request in the retiring cycle is judged before the retirement
    reserve(8, 1, 1);
    #1;
    chk("R9 full", int'(free_slots), 0);
    mark(1, 0);
    rsv_valid = 1'b1;
    rsv_uops  = 4'd1;
    #1;
    chk("R9 retiring", int'(ret_num), 1);
    chk("R9 stall", int'(rsv_stall), 1);
    @(posedge clk);
    @(negedge clk);
    rsv_valid = 1'b0;
    #1;
    chk("R9 freed", int'(free_slots), 8);
    reserve(1, 1, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule